// File: doc/BRIEF.md
# Laser Transmitter Turn-On and Fault Sequencer

This block controls the optical outputs of a multi-channel laser transmitter. It watches four control inputs (an active-high disable, an active-high enable, an active-low control reset and a supply-good flag). It also watches three kinds of fault input: over-current per channel, over-temperature and corrupted calibration. From these it drives one enable line per channel and an active-low fault status line. Every control and fault input is asynchronous and passes through a two-flop synchronizer before the logic uses it.

The channels are allowed to run only when all four controls permit it and no fault is latched. When this run condition appears, the sequencer waits a settle delay and then turns the channels on one at a time, in ascending order and at a fixed spacing. The first run after the supply becomes good uses a longer power-up delay in place of the settle delay. Losing the run condition turns every channel off at once, including partway through the ramp. The ramp then starts over from channel 0 when the condition returns.

A detected fault is latched and forces all channels off. It clears on a falling edge of the control reset, or after the enable is low or the disable is high for a minimum recovery time. All delays are parameters counted in clock cycles.

Top module: `laser_tx_seq`

## Requirements
- R1: Channels may be on only while disable is low, enable is high, control reset is high and supply good is high. If any of these does not hold on three consecutive rising edges, all channel enables are 0 after the third edge (two synchronizer stages plus one state register).
- R2: fault_no_o is 1 when no fault is latched. A fault source (any bit of over_cur_i, over_temp_i or cal_bad_i) that appears before a rising edge drives fault_no_o to 0 after the third rising edge.
- R3: A latched fault turns all channel enables to 0 one cycle after fault_no_o falls. The fault stays latched after every source has returned to 0.
- R4: A falling edge of the synchronized control reset clears a latched fault. A low pulse lasting at least one clock cycle is enough.
- R5: A latched fault is cleared once the synchronized enable is low, or the synchronized disable is high, on T_RECOVER consecutive cycles. A shorter idle period leaves the fault latched.
- R6: A fault that arrives while the control reset is held low stays latched after the control reset is released.
- R7: On a warm start, channel 0 turns on T_SETTLE+3 rising edges after the run condition is applied. Channel i then turns on T_STEP rising edges after channel i-1. The enables always form a contiguous run of ones starting at bit 0, so the turn-on order is ascending.
- R8: A start that follows a low supply-good flag, including the first start after chip reset, uses T_PWRUP in place of T_SETTLE for channel 0.
- R9: If the run condition drops partway through the ramp, all channels turn off. When the condition returns, the sequence restarts at channel 0 with the full settle delay.
- R10: During and right after chip reset (rst_ni low), all channel enables are 0 and fault_no_o is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous chip reset, active low |
| tx_off_i | input | 1 | Transmit disable, active high |
| tx_on_i | input | 1 | Transmit enable, active high |
| tx_rst_ni | input | 1 | Control reset, active low; falling edge clears a latched fault |
| pwr_good_i | input | 1 | Supply above its turn-on threshold |
| over_cur_i | input | N_CH | Per-channel over-current flags |
| over_temp_i | input | 1 | Temperature out of range |
| cal_bad_i | input | 1 | Calibration data corrupted |
| chan_en_o | output | N_CH | Per-channel laser enable |
| fault_no_o | output | 1 | Latched fault status, active low |

## Verification
On every cycle, the assertions check the following: the turn-on order as a contiguous run of ones, the rule of at most one new channel per cycle, the forced shutdown that follows a low fault status, and the three-edge shutdown after each of the four control conditions is lost. Other behaviours depend on history that spans many cycles, so only the bench's directed scenarios show them. These are the exact settle, power-up and spacing delays, the difference between a cold and a warm start, the fault latch's hold and its two clear paths (including a recovery pulse that is too short), the fault that arrives during a reset pulse, and the restart from channel 0 after an aborted ramp.

// File: rtl/laser_tx_pkg.sv
package laser_tx_pkg;
  typedef enum logic [1:0] {
    SEQ_OFF  = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_RAMP = 2'd2,
    SEQ_ON   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/ltx_sync.sv
module ltx_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/ltx_fault_latch.sv
module ltx_fault_latch #(
  parameter int CNT_W     = 16,
  parameter int T_RECOVER = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flt_i,      // synchronized, any source
  input  logic ctl_rst_ni, // synchronized control reset
  input  logic idle_i,     // synchronized enable low or disable high
  output logic fault_o
);
  localparam logic [CNT_W-1:0] REC_LAST = CNT_W'(T_RECOVER - 1);
  localparam logic [CNT_W-1:0] REC_SAT  = CNT_W'(T_RECOVER);

  logic [CNT_W-1:0] rcnt_q;
  logic             rst_d_q;
  logic             fault_q;
  logic             clr_rst, clr_rec;

  assign clr_rst = rst_d_q && !ctl_rst_ni;
  assign clr_rec = idle_i && (rcnt_q == REC_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rcnt_q  <= '0;
      rst_d_q <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      rst_d_q <= ctl_rst_ni;
      if (!idle_i)               rcnt_q <= '0;
      else if (rcnt_q != REC_SAT) rcnt_q <= rcnt_q + 1'b1;
      // a new fault wins over any clear in the same cycle
      if (flt_i)                   fault_q <= 1'b1;
      else if (clr_rst || clr_rec) fault_q <= 1'b0;
    end
  end

  assign fault_o = fault_q;
endmodule

// File: rtl/ltx_seq_fsm.sv
module ltx_seq_fsm
  import laser_tx_pkg::*;
#(
  parameter int N_CH     = 4,
  parameter int CNT_W    = 16,
  parameter int T_PWRUP  = 325000,
  parameter int T_SETTLE = 210000,
  parameter int T_STEP   = 230000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            go_i,
  input  logic            pg_i,
  output logic [N_CH-1:0] en_o
);
  localparam int IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1;
  localparam logic [CNT_W-1:0] PWR_LAST  = CNT_W'(T_PWRUP - 1);
  localparam logic [CNT_W-1:0] SET_LAST  = CNT_W'(T_SETTLE - 1);
  localparam logic [CNT_W-1:0] STEP_LAST = CNT_W'(T_STEP - 1);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(N_CH - 1);

  seq_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [N_CH-1:0]  en_q;
  logic             cold_q;
  logic [CNT_W-1:0] first_last;

  assign first_last = cold_q ? PWR_LAST : SET_LAST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SEQ_OFF;
      cnt_q  <= '0;
      idx_q  <= '0;
      en_q   <= '0;
      cold_q <= 1'b1;
    end else begin
      if (!pg_i) cold_q <= 1'b1;
      if (!go_i) begin
        st_q  <= SEQ_OFF;
        cnt_q <= '0;
        idx_q <= '0;
        en_q  <= '0;
      end else begin
        case (st_q)
          SEQ_OFF: begin
            st_q  <= SEQ_WAIT;
            cnt_q <= '0;
          end
          SEQ_WAIT: begin
            if (cnt_q == first_last) begin
              en_q[0] <= 1'b1;
              cold_q  <= 1'b0;
              cnt_q   <= '0;
              idx_q   <= IDX_W'(1);
              st_q    <= (N_CH == 1) ? SEQ_ON : SEQ_RAMP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          SEQ_RAMP: begin
            if (cnt_q == STEP_LAST) begin
              en_q[idx_q] <= 1'b1;
              cnt_q       <= '0;
              if (idx_q == IDX_LAST) st_q  <= SEQ_ON;
              else                   idx_q <= idx_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          SEQ_ON:  st_q <= SEQ_ON;
          default: st_q <= SEQ_OFF;
        endcase
      end
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/laser_tx_seq.sv
module laser_tx_seq #(
  parameter int N_CH      = 4,
  parameter int T_PWRUP   = 325000,
  parameter int T_SETTLE  = 210000,
  parameter int T_STEP    = 230000,
  parameter int T_RECOVER = 50000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tx_off_i,
  input  logic            tx_on_i,
  input  logic            tx_rst_ni,
  input  logic            pwr_good_i,
  input  logic [N_CH-1:0] over_cur_i,
  input  logic            over_temp_i,
  input  logic            cal_bad_i,
  output logic [N_CH-1:0] chan_en_o,
  output logic            fault_no_o
);
  localparam int MAX_A = (T_PWRUP > T_SETTLE) ? T_PWRUP : T_SETTLE;
  localparam int MAX_B = (T_STEP > T_RECOVER) ? T_STEP : T_RECOVER;
  localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_T + 1);
  localparam int SYNC_W = N_CH + 6;

  logic [SYNC_W-1:0] raw, syn;
  logic off_s, on_s, rst_s, pg_s, any_flt_s, idle_s;
  logic fault_q, go;

  assign raw = {cal_bad_i, over_temp_i, over_cur_i, pwr_good_i, tx_rst_ni, tx_on_i, tx_off_i};

  ltx_sync #(.W(SYNC_W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign off_s     = syn[0];
  assign on_s      = syn[1];
  assign rst_s     = syn[2];
  assign pg_s      = syn[3];
  assign any_flt_s = |syn[SYNC_W-1:4];
  assign idle_s    = !on_s || off_s;

  ltx_fault_latch #(.CNT_W(CNT_W), .T_RECOVER(T_RECOVER)) u_flt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flt_i     (any_flt_s),
    .ctl_rst_ni(rst_s),
    .idle_i    (idle_s),
    .fault_o   (fault_q)
  );

  assign go = !off_s && on_s && rst_s && pg_s && !fault_q;

  ltx_seq_fsm #(
    .N_CH(N_CH), .CNT_W(CNT_W), .T_PWRUP(T_PWRUP),
    .T_SETTLE(T_SETTLE), .T_STEP(T_STEP)
  ) u_fsm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .go_i  (go),
    .pg_i  (pg_s),
    .en_o  (chan_en_o)
  );

  assign fault_no_o = !fault_q;
endmodule

// File: rtl/laser_tx_seq_chk.sv
module laser_tx_seq_chk #(
  parameter int N_CH = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            tx_off_i,
  input logic            tx_on_i,
  input logic            tx_rst_ni,
  input logic            pwr_good_i,
  input logic [N_CH-1:0] chan_en_o,
  input logic            fault_no_o
);
  p_contiguous_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((chan_en_o + N_CH'(1)) & chan_en_o) == '0);

  p_one_per_cycle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(chan_en_o) <= $countones($past(chan_en_o)) + 1);

  p_fault_forces_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_no_o |=> (chan_en_o == '0));

  p_off_on_disable_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(tx_off_i) && $past(tx_off_i, 2) && $past(tx_off_i, 3)) |-> (chan_en_o == '0));

  p_off_on_no_enable_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(tx_on_i) && !$past(tx_on_i, 2) && !$past(tx_on_i, 3)) |-> (chan_en_o == '0));

  p_off_on_ctl_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(tx_rst_ni) && !$past(tx_rst_ni, 2) && !$past(tx_rst_ni, 3)) |-> (chan_en_o == '0));

  p_off_on_supply_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(pwr_good_i) && !$past(pwr_good_i, 2) && !$past(pwr_good_i, 3)) |-> (chan_en_o == '0));
endmodule

bind laser_tx_seq laser_tx_seq_chk #(.N_CH(N_CH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tx_off_i  (tx_off_i),
  .tx_on_i   (tx_on_i),
  .tx_rst_ni (tx_rst_ni),
  .pwr_good_i(pwr_good_i),
  .chan_en_o (chan_en_o),
  .fault_no_o(fault_no_o)
);

// File: tb/laser_tx_seq_tb_top.sv
`timescale 1ns/1ps
module laser_tx_seq_tb_top;
  localparam int N  = 4;
  localparam int TP = 40;
  localparam int TS = 20;
  localparam int TT = 10;
  localparam int TR = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tx_off = 1'b0, tx_on = 1'b1, tx_rst_n = 1'b1, pg = 1'b0;
  logic [N-1:0] ovc = '0;
  logic ovt = 1'b0, cal = 1'b0;
  logic [N-1:0] en;
  logic fault_n;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  laser_tx_seq #(.N_CH(N), .T_PWRUP(TP), .T_SETTLE(TS), .T_STEP(TT), .T_RECOVER(TR)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tx_off_i(tx_off), .tx_on_i(tx_on), .tx_rst_ni(tx_rst_n),
    .pwr_good_i(pg), .over_cur_i(ovc), .over_temp_i(ovt), .cal_bad_i(cal),
    .chan_en_o(en), .fault_no_o(fault_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_rise(input int ch, output int n);
    n = 0;
    while (!en[ch] && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic ramp_check(input string req, input int first_exp);
    int n;
    count_rise(0, n);
    chk({req, " ch0 delay"}, n, first_exp);
    chk({req, " ch0 alone"}, int'(en), 1);
    for (int c = 1; c < N; c++) begin
      count_rise(c, n);
      chk($sformatf("R7 ch%0d spacing", c), n, TT);
      chk($sformatf("R7 order at ch%0d", c), int'(en), (1 << (c + 1)) - 1);
    end
  endtask

  task automatic t_reset;
    chk("R10 enables in reset", int'(en), 0);
    chk("R10 status in reset", int'(fault_n), 1);
    @(negedge clk); rst_ni = 1'b1;
    cyc(8);
    chk("R1 supply low keeps off", int'(en), 0);
    chk("R10 status after reset", int'(fault_n), 1);
  endtask

  task automatic t_cold;
    @(negedge clk); pg = 1'b1;
    ramp_check("R8 cold", TP + 3);
  endtask

  task automatic t_shutdown;
    @(negedge clk); tx_off = 1'b1;
    cyc(2);
    chk("R1 disable: on before 3rd edge", int'(en), 15);
    cyc(1);
    chk("R1 disable: off after 3rd edge", int'(en), 0);
    @(negedge clk); tx_off = 1'b0;
    ramp_check("R7 warm", TS + 3);
    @(negedge clk); tx_rst_n = 1'b0;
    cyc(3);
    chk("R1 control reset off", int'(en), 0);
    @(negedge clk); tx_rst_n = 1'b1; tx_off = 1'b1;
    cyc(TS + 10);
    chk("R1 enable and disable both high stays off", int'(en), 0);
    @(negedge clk); tx_off = 1'b0;
    ramp_check("R7 warm", TS + 3);
    @(negedge clk); tx_on = 1'b0;
    cyc(3);
    chk("R1 enable low off", int'(en), 0);
    @(negedge clk); tx_on = 1'b1;
    ramp_check("R7 warm", TS + 3);
    @(negedge clk); pg = 1'b0;
    cyc(3);
    chk("R1 supply low off", int'(en), 0);
    @(negedge clk); pg = 1'b1;
    ramp_check("R8 cold after supply loss", TP + 3);
  endtask

  task automatic t_fault(input int src);
    int n;
    @(negedge clk);
    case (src)
      0: ovc[2] = 1'b1;
      1: ovt = 1'b1;
      2: cal = 1'b1;
      default: ovc[0] = 1'b1;
    endcase
    cyc(2);
    chk("R2 status high before 3rd edge", int'(fault_n), 1);
    cyc(1);
    chk($sformatf("R2 status low, source %0d", src), int'(fault_n), 0);
    chk("R3 enables still on the flag cycle", int'(en), 15);
    cyc(1);
    chk("R3 enables off after flag", int'(en), 0);
    ovc = '0; ovt = 1'b0; cal = 1'b0;
    cyc(TS + 20);
    chk("R3 fault held after sources clear", int'(fault_n), 0);
    chk("R3 enables held off", int'(en), 0);
    tx_rst_n = 1'b0;
    cyc(4);
    chk("R4 reset pulse clears fault", int'(fault_n), 1);
    tx_rst_n = 1'b1;
    count_rise(N - 1, n);
    chk("R4 channels return after clear", int'(en), 15);
  endtask

  task automatic t_recover;
    @(negedge clk); ovt = 1'b1;
    cyc(3); ovt = 1'b0;
    cyc(3);
    chk("R5 fault latched", int'(fault_n), 0);
    tx_on = 1'b0;
    cyc(TR - 4);
    tx_on = 1'b1;
    cyc(10);
    chk("R5 short idle leaves fault", int'(fault_n), 0);
    chk("R5 short idle, channels off", int'(en), 0);
    tx_off = 1'b1;
    cyc(TR + 4);
    chk("R5 long idle clears fault", int'(fault_n), 1);
    chk("R1 still off while disabled", int'(en), 0);
    @(negedge clk); tx_off = 1'b0;
    ramp_check("R5 warm after recovery", TS + 3);
  endtask

  task automatic t_fault_in_reset;
    @(negedge clk); tx_rst_n = 1'b0;
    cyc(6);
    cal = 1'b1;
    cyc(3); cal = 1'b0;
    cyc(5);
    tx_rst_n = 1'b1;
    cyc(TS + 10);
    chk("R6 fault survives reset release", int'(fault_n), 0);
    chk("R6 channels stay off", int'(en), 0);
    tx_rst_n = 1'b0;
    cyc(4);
    tx_rst_n = 1'b1;
    cyc(2);
    chk("R4 second pulse clears", int'(fault_n), 1);
  endtask

  task automatic t_abort;
    int n;
    count_rise(1, n);
    @(negedge clk); tx_off = 1'b1;
    cyc(3);
    chk("R9 abort turns all off", int'(en), 0);
    cyc(5);
    @(negedge clk); tx_off = 1'b0;
    count_rise(0, n);
    chk("R9 restart uses full settle", n, TS + 3);
    chk("R9 restart from channel 0", int'(en), 1);
    count_rise(N - 1, n);
  endtask

  initial begin
    #(4ms);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(5);
    t_reset();
    t_cold();
    t_shutdown();
    for (int s = 0; s < 4; s++) t_fault(s);
    t_recover();
    t_fault_in_reset();
    t_abort();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule